// File: doc/BRIEF.md
# Streaming CRC-32 Generator and Checker

This block computes a 32-bit cyclic redundancy check over a byte stream. One byte enters per clock on a valid/ready input. A start strobe on the first beat reloads the running remainder with all ones. An end strobe on the last beat closes the frame. That last beat may carry fewer than eight meaningful bits, and a 3-bit count gives how many. One cycle after the closing beat, the block presents the inverted remainder as the code to append to the message. In the same cycle it raises a pass flag when the frame it just closed was a message followed by its own correct code.

A parameter selects the bit order. In reflected order each byte is consumed least-significant bit first, against the bit-reversed polynomial. In normal order each byte is consumed most-significant bit first, against the plain polynomial. Each byte passes through an unrolled network of eight shift-and-conditional-XOR steps. A short tail uses only as many of those steps as it has valid bits.

Top module: `crc32_stream`

## Requirements
- R1: After reset release, `in_ready` is 1 from the first clock edge on, and `crc_valid`, `crc_out` and `crc_pass` are all 0 until the first frame closes.
- R2: A beat accepted with `in_sof`=1 starts from a remainder of 0xFFFFFFFF, whatever came before it. Because of this start value, a frame of one zero byte and a frame of two zero bytes give different codes.
- R3: With `MSB_FIRST`=0, each byte is taken bit 0 first against polynomial 0xEDB88320, and the ASCII string "123456789" yields `crc_out` = 0xCBF43926.
- R4: With `MSB_FIRST`=1, each byte is taken bit 7 first against polynomial 0x04C11DB7, and "123456789" yields `crc_out` = 0xFC891918.
- R5: On the closing beat, `in_nbits` gives the number of valid bits, with 0 meaning 8. The valid bits are `in_data[n-1:0]` (bit 0 first) in reflected order and `in_data[7:8-n]` (bit 7 first) in normal order. The other data bits have no effect. On beats that do not close a frame, `in_nbits` is ignored and all 8 bits are used.
- R6: `crc_valid` is 1 exactly in the cycle after a beat with `in_eof`=1 is accepted, and 0 at all other times. `crc_out` then holds the bitwise inverse of the final remainder and keeps that value until the next frame closes.
- R7: `crc_pass` is set when a frame closes and the final remainder equals 0xDEBB20E3 (reflected order) or 0xC704DD7B (normal order). The check frame is a message followed by its code: in reflected order the code is sent low byte first, and in normal order it is sent high byte first. Such a frame passes. The same frame with any bit flipped fails, and so does the same frame with a zero byte added at the end.
- R8: A cycle with `in_valid`=0 leaves the remainder untouched, whatever is on the data and strobe inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present on the data inputs |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_sof | input | 1 | First beat of a frame; reload the remainder |
| in_eof | input | 1 | Last beat of a frame |
| in_data | input | 8 | Message byte |
| in_nbits | input | 3 | Valid bits on the closing beat, 0 means 8 |
| crc_valid | output | 1 | One-cycle strobe after a frame closes |
| crc_out | output | 32 | Inverted final remainder, the code to append |
| crc_pass | output | 1 | Closed frame left the good-frame residue |

## Verification
The bench checks the known string in both bit orders. Code from a wrong polynomial, wrong shift direction or wrong start value would produce the wrong code here.

Short tails are sent twice: once with the unused bits cleared and once with them filled with noise. A design that masked the wrong side of the byte, or ran eight steps on a short tail, would give different codes for the two. Frames are replayed with idle gaps full of junk, after an unfinished stream that is cut off by a new start, and with stray bit counts on middle beats. A design that let any of these leak into the remainder would show a code mismatch. Frames with their own code appended are checked as they are, with one bit flipped, and with a zero byte added. A residue compare on the wrong constant, or taken before the last step, would flag good frames as bad or bad frames as good.

// File: rtl/crc32_stream.sv
module crc32_stream #(
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic [2:0]  in_nbits,
  output logic        crc_valid,
  output logic [31:0] crc_out,
  output logic        crc_pass
);

  localparam logic [31:0] POLY    = MSB_FIRST ? 32'h04C11DB7 : 32'hEDB88320;
  localparam logic [31:0] RESIDUE = MSB_FIRST ? 32'hC704DD7B : 32'hDEBB20E3;
  localparam logic [31:0] SEED    = 32'hFFFFFFFF;

  logic [31:0]      rem_q;
  logic [31:0]      base;
  logic [3:0]       nsteps;
  logic [3:0]       nskip;
  logic [7:0]       dmask;
  logic [7:0]       dbits;
  logic [8:0][31:0] stg;
  logic [31:0]      nxt;
  logic             acc;

  assign acc    = in_valid && in_ready;
  assign base   = in_sof ? SEED : rem_q;
  assign nsteps = (in_eof && in_nbits != 3'd0) ? {1'b0, in_nbits} : 4'd8;
  assign nskip  = 4'd8 - nsteps;
  assign dmask  = MSB_FIRST ? (8'hFF << nskip) : (8'hFF >> nskip);
  assign dbits  = in_data & dmask;
  assign stg[0] = MSB_FIRST ? (base ^ {dbits, 24'd0}) : (base ^ {24'd0, dbits});

  generate
    for (genvar k = 0; k < 8; k++) begin : g_step
      if (MSB_FIRST) begin : g_left
        assign stg[k+1] = {stg[k][30:0], 1'b0} ^ (stg[k][31] ? POLY : 32'd0);
      end else begin : g_right
        assign stg[k+1] = {1'b0, stg[k][31:1]} ^ (stg[k][0] ? POLY : 32'd0);
      end
    end
  endgenerate

  assign nxt = stg[nsteps];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= SEED;
      in_ready  <= 1'b0;
      crc_valid <= 1'b0;
      crc_out   <= 32'd0;
      crc_pass  <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      crc_valid <= acc && in_eof;
      if (acc) rem_q <= nxt;
      if (acc && in_eof) begin
        crc_out  <= ~nxt;
        crc_pass <= (nxt == RESIDUE);
      end
    end
  end

  // R6
  eof_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_eof) |=> crc_valid);

  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> $past(acc && in_eof));

  // R6
  out_matches_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> (crc_out == ~rem_q));

  // R7
  pass_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_pass |-> (crc_out == ~RESIDUE));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(rem_q));

endmodule

// File: tb/crc32_stream_tb.sv
module crc32_stream_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic [2:0] in_nbits = 3'd0;

  logic rdy_r, v_r, p_r, rdy_m, v_m, p_m;
  logic [31:0] c_r, c_m;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  crc32_stream #(.MSB_FIRST(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_r),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .in_nbits(in_nbits),
    .crc_valid(v_r), .crc_out(c_r), .crc_pass(p_r));

  crc32_stream #(.MSB_FIRST(1'b1)) dut_msb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_m),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .in_nbits(in_nbits),
    .crc_valid(v_m), .crc_out(c_m), .crc_pass(p_m));

  function automatic logic [31:0] feed(input logic [31:0] r0, input logic [7:0] d,
                                       input int n, input bit msb);
    logic [31:0] r = r0;
    for (int i = 0; i < n; i++) begin
      bit b, fb;
      if (msb) begin
        b = d[7-i]; fb = r[31] ^ b; r = r << 1;
        if (fb) r = r ^ 32'h04C11DB7;
      end else begin
        b = d[i]; fb = r[0] ^ b; r = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, both orders
  logic [31:0] mrem [2];
  logic [31:0] mcrc [2];
  logic        mval [2];
  logic        mpass[2];
  logic [31:0] resid[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < 2; m++) begin
        mrem[m] = 32'hFFFFFFFF; mcrc[m] = 0; mval[m] = 0; mpass[m] = 0;
      end
    end else begin
      for (int m = 0; m < 2; m++) begin
        logic rdy;
        rdy = (m == 0) ? rdy_r : rdy_m;
        mval[m] = 1'b0;
        if (in_valid && rdy) begin
          logic [31:0] b;
          int n;
          b = in_sof ? 32'hFFFFFFFF : mrem[m];
          n = (in_eof && in_nbits != 0) ? int'(in_nbits) : 8;
          mrem[m] = feed(b, in_data, n, m == 1);
          if (in_eof) begin
            mval[m] = 1'b1; mcrc[m] = ~mrem[m]; mpass[m] = (mrem[m] == resid[m]);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(v_r == mval[0], "R6 valid refl", 32'(v_r), 32'(mval[0]));
      check(v_m == mval[1], "R6 valid msb", 32'(v_m), 32'(mval[1]));
      check(c_r == mcrc[0], "R3 crc refl", c_r, mcrc[0]);
      check(c_m == mcrc[1], "R4 crc msb", c_m, mcrc[1]);
      check(p_r == mpass[0], "R7 pass refl", 32'(p_r), 32'(mpass[0]));
      check(p_m == mpass[1], "R7 pass msb", 32'(p_m), 32'(mpass[1]));
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_data = 8'($urandom); in_sof = 1'($urandom);
      in_eof = 1'($urandom); in_nbits = 3'($urandom);
    end
  endtask

  // tail: valid bits in last byte, 0 means 8; last byte taken as given
  task automatic send_frame(input logic [7:0] q[$], input int tail, input int gapmax,
                            input bit sof = 1'b1, input bit eof = 1'b1);
    for (int i = 0; i < q.size(); i++) begin
      if (gapmax > 0) idle($urandom_range(gapmax, 0));
      @(negedge clk);
      in_valid = 1'b1; in_data = q[i];
      in_sof = sof && (i == 0);
      in_eof = eof && (i == q.size() - 1);
      in_nbits = in_eof ? 3'(tail) : 3'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  initial begin
    logic [7:0] msg[$];
    logic [7:0] fr[$];
    logic [31:0] r, cr, cm, a1, a2, b1, b2;
    msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    // residues derived from a known-good frame, per order
    r = 32'hFFFFFFFF;
    foreach (msg[i]) r = feed(r, msg[i], 8, 1'b0);
    cr = ~r;
    for (int k = 0; k < 4; k++) r = feed(r, cr[8*k +: 8], 8, 1'b0);
    resid[0] = r;
    r = 32'hFFFFFFFF;
    foreach (msg[i]) r = feed(r, msg[i], 8, 1'b1);
    cm = ~r;
    for (int k = 3; k >= 0; k--) r = feed(r, cm[8*k +: 8], 8, 1'b1);
    resid[1] = r;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    check(rdy_r && rdy_m, "R1 ready", 32'({rdy_r, rdy_m}), 32'h3);
    check(!v_r && !v_m && !p_r && !p_m, "R1 flags", 32'({v_r, v_m, p_r, p_m}), 32'h0);
    check(c_r == 0 && c_m == 0, "R1 crc", c_r | c_m, 32'h0);

    // R3 / R4 known string
    send_frame(msg, 0, 0);
    check(c_r == 32'hCBF43926, "R3 check string", c_r, 32'hCBF43926);
    check(c_m == 32'hFC891918, "R4 check string", c_m, 32'hFC891918);
    check(v_r && v_m, "R6 strobe", 32'({v_r, v_m}), 32'h3);
    @(negedge clk);
    check(!v_r && c_r == 32'hCBF43926, "R6 hold", c_r, 32'hCBF43926);

    // R2 start reloads seed
    send_frame('{8'hAA, 8'h55, 8'h0F}, 0, 0, 1'b1, 1'b0);
    send_frame(msg, 0, 0);
    check(c_r == 32'hCBF43926, "R2 reload refl", c_r, 32'hCBF43926);
    check(c_m == 32'hFC891918, "R2 reload msb", c_m, 32'hFC891918);
    send_frame('{8'h00}, 0, 0);
    a1 = c_r;
    send_frame('{8'h00, 8'h00}, 0, 0);
    check(c_r != a1, "R2 leading zero", c_r, ~a1);

    // R8 idle gaps with junk
    send_frame(msg, 0, 4);
    check(c_r == 32'hCBF43926, "R8 gaps refl", c_r, 32'hCBF43926);
    check(c_m == 32'hFC891918, "R8 gaps msb", c_m, 32'hFC891918);

    // R7 reflected good, flipped, trailing zero
    fr = msg;
    for (int k = 0; k < 4; k++) fr.push_back(cr[8*k +: 8]);
    send_frame(fr, 0, 0);
    check(p_r == 1'b1, "R7 good refl", 32'(p_r), 32'h1);
    fr[3] = fr[3] ^ 8'h10;
    send_frame(fr, 0, 0);
    check(p_r == 1'b0, "R7 flip refl", 32'(p_r), 32'h0);
    fr[3] = fr[3] ^ 8'h10;
    fr.push_back(8'h00);
    send_frame(fr, 0, 0);
    check(p_r == 1'b0, "R7 trailing zero refl", 32'(p_r), 32'h0);

    // R7 normal order good and flipped
    fr = msg;
    for (int k = 3; k >= 0; k--) fr.push_back(cm[8*k +: 8]);
    send_frame(fr, 0, 2);
    check(p_m == 1'b1, "R7 good msb", 32'(p_m), 32'h1);
    fr[10] = fr[10] ^ 8'h01;
    send_frame(fr, 0, 0);
    check(p_m == 1'b0, "R7 flip msb", 32'(p_m), 32'h0);

    // R5 tail masking
    fr = msg; fr[8] = 8'h05;
    send_frame(fr, 3, 0); a1 = c_r;
    fr[8] = 8'hFD;
    send_frame(fr, 3, 0); a2 = c_r;
    check(a1 == a2, "R5 refl unused bits", a2, a1);
    r = 32'hFFFFFFFF;
    for (int i = 0; i < 8; i++) r = feed(r, msg[i], 8, 1'b0);
    r = feed(r, 8'h05, 3, 1'b0);
    check(a1 == ~r, "R5 refl tail value", a1, ~r);
    fr[8] = 8'hA0;
    send_frame(fr, 3, 0); b1 = c_m;
    fr[8] = 8'hBF;
    send_frame(fr, 3, 0); b2 = c_m;
    check(b1 == b2, "R5 msb unused bits", b2, b1);
    send_frame('{8'h01}, 1, 0);
    send_frame(msg, 0, 0);
    check(c_r == 32'hCBF43926, "R5 nbits ignored mid-frame", c_r, 32'hCBF43926);

    // random frames, model compared every clock
    for (int f = 0; f < 300; f++) begin
      int len;
      len = $urandom_range(12, 1);
      fr = {};
      for (int i = 0; i < len; i++) fr.push_back(8'($urandom));
      send_frame(fr, $urandom_range(7, 0), $urandom_range(2, 0));
    end

    idle(3);
    finish_run();
  end
endmodule